// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing protocol engine of a 256-byte serial EEPROM. It oversamples the serial clock and data lines with a fast system clock and recognises start and stop conditions. It checks the device select byte against a fixed type code and three strap inputs. It acknowledges each accepted byte by pulling the data line low. It also keeps the internal word pointer that all transfers use.

Write transfers place each received data byte, with its target address, into a staging port. A separate write-cycle controller collects these bytes. On a stop that follows at least one staged byte, the engine raises a commit pulse. If a start arrives instead, it raises a cancel pulse. While that controller reports a write cycle in progress, the engine does not acknowledge its select byte, so a master can poll for completion. Read data comes combinationally from a behavioural array through an address/data pair. The data line is never driven high: the only output toward it is a pull-low enable.

The sequencer has the following states:
- `S_IDLE` is entered after a stop and after reset.
- `S_DEV` receives the select byte.
- `S_DEV_ACK` acknowledges the select byte.
- `S_WADDR` and `S_WADDR_ACK` take in and acknowledge the word address.
- `S_WDATA` and `S_WDATA_ACK` take in and acknowledge data bytes.
- `S_RDATA` shifts a byte out.
- `S_RACK` samples the master's acknowledge.
- `S_RNEXT` waits for the falling edge before the next byte is loaded.
- `S_WAIT` ignores the bus until the next start.

The transitions are as follows:
- A start moves any state to `S_DEV`.
- A stop moves any state to `S_IDLE`.
- `S_DEV` goes to `S_DEV_ACK` on a match while no write cycle is in progress. Otherwise it goes to `S_WAIT`.
- `S_DEV_ACK` goes to `S_RDATA` when the request bit asks for a read, and to `S_WADDR` when it asks for a write.
- `S_WADDR` goes to `S_WADDR_ACK`, and `S_WADDR_ACK` goes to `S_WDATA`.
- `S_WDATA` and `S_WDATA_ACK` alternate.
- `S_RDATA` goes to `S_RACK` after eight bits.
- `S_RACK` goes to `S_RNEXT` when the master acknowledges, and to `S_WAIT` when it does not.
- `S_RNEXT` goes back to `S_RDATA`.

Top module: `eeprom_twi_slave`

## Requirements
- R1: A falling data line while the clock is high is a start, and it restarts select-byte reception from any state. A rising data line while the clock is high is a stop, and it returns the engine to idle.
- R2: The select byte carries the type code 1010 in bits 7..4, the strap value in bits 3..1, and in bit 0 a request bit where 1 means read. On a match the engine pulls the data line low for the whole ninth clock.
- R3: A select byte that does not match is not acknowledged, and the engine ignores the bus until the next start.
- R4: While `wcyc_busy_i` is high a matching select byte is not acknowledged. Once it is low, the same byte is acknowledged.
- R5: In a write, the byte after the select byte is loaded as the word pointer. Each following data byte is acknowledged and staged at the pointer. After each data byte, pointer bits 2..0 increment and wrap inside the 8-byte page while bits 7..3 are kept.
- R6: A stop after at least one staged byte gives one `commit_o` pulse. A start after staged bytes gives one `cancel_o` pulse and no commit. A write holding only a word address commits nothing.
- R7: A current-address read returns the byte at the pointer, which holds the last accessed address plus one.
- R8: A random read, meaning a word-address write, then a repeated start, then a read select byte, returns the byte at the written word address.
- R9: During a read, each byte the master acknowledges is followed by the byte at the next address. The address wraps from 255 to 0.
- R10: After the master does not acknowledge a read byte, the engine releases the data line and drives nothing until the next start.
- R11: The recovery sequence returns the engine to idle from the middle of a read, ready for the next transfer. The sequence is a start, nine clocks, another start, then a stop.
- R12: The pull-low enable changes only while the synchronised clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_low_o | output | 1 | Pull-low enable for the open-drain data line |
| chip_sel_i | input | 3 | Strapped select bits compared with select byte bits 3..1 |
| wcyc_busy_i | input | 1 | Write cycle in progress, from the write-cycle controller |
| stg_we_o | output | 1 | One-cycle strobe: a data byte is staged |
| stg_addr_o | output | 8 | Address of the staged byte |
| stg_data_o | output | 8 | Staged data byte |
| commit_o | output | 1 | One-cycle pulse: start the write cycle for staged bytes |
| cancel_o | output | 1 | One-cycle pulse: drop staged bytes |
| mem_addr_o | output | 8 | Read address into the array (the word pointer) |
| mem_data_i | input | 8 | Array byte at `mem_addr_o`, combinational |

## Verification
The assertions assume a master that holds each clock level for several system clocks. With that assumption, a start or stop can never share a cycle with a detected clock edge, and the pull-low enable always settles before the clock rises again. The assertions also assume that start and stop are only formed while the engine has released the data line. The bench keeps to this by making every bus phase five system clocks long. It also changes its own data only a quarter period after a clock fall. Its recovery sequence releases the line and lets the engine's pending bits and the missing acknowledge run out before it forms a real start.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_RNEXT,
        S_WAIT
    } eng_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d_i[gi]};
            end
            assign q_o[gi] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int AW = 8,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_lin_i,
    input  logic          inc_page_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ptr_q <= '0;
        else if (load_i)     ptr_q <= load_val_i;
        else if (inc_page_i) ptr_q <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
        else if (inc_lin_i)  ptr_q <= ptr_q + AW'(1);
    end

    assign ptr_o = ptr_q;

    AST_ONE_PTR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load_i, inc_lin_i, inc_page_i}) <= 1); // R9

    AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page_i |=> ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW])); // R5
endmodule

// File: rtl/twi_fsm.sv
module twi_fsm
    import twi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b1010,
    parameter int         AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic [2:0]    chip_sel_i,
    input  logic          busy_i,
    input  logic [BYTE_W-1:0] mem_data_i,
    input  logic [AW-1:0] ptr_i,
    output logic          sda_low_o,
    output logic          stg_we_o,
    output logic [AW-1:0] stg_addr_o,
    output logic [BYTE_W-1:0] stg_data_o,
    output logic          commit_o,
    output logic          cancel_o,
    output logic          ctr_load_o,
    output logic [AW-1:0] ctr_val_o,
    output logic          ctr_inc_lin_o,
    output logic          ctr_inc_page_o
);
    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);

    eng_state_t state_q, state_d;

    logic scl_q, sda_q;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [CW-1:0] cnt_q;
    logic [BYTE_W-1:0] shreg_q, tx_q, rx_byte;
    logic ack_on_q, rw_q, staged_q;
    logic last_bit, dev_match;

    // bus event detection on the synchronised lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

    assign rx_byte   = {shreg_q[BYTE_W-2:0], sda_s};
    assign last_bit  = (cnt_q == CNT_LAST);
    assign dev_match = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == chip_sel_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_WAIT: state_d = state_q;
            S_DEV:
                if (scl_rise && last_bit)
                    state_d = (dev_match && !busy_i) ? S_DEV_ACK : S_WAIT;
            S_DEV_ACK:
                if (scl_fall && ack_on_q)
                    state_d = rw_q ? S_RDATA : S_WADDR;
            S_WADDR:
                if (scl_rise && last_bit) state_d = S_WADDR_ACK;
            S_WADDR_ACK:
                if (scl_fall && ack_on_q) state_d = S_WDATA;
            S_WDATA:
                if (scl_rise && last_bit) state_d = S_WDATA_ACK;
            S_WDATA_ACK:
                if (scl_fall && ack_on_q) state_d = S_WDATA;
            S_RDATA:
                if (scl_fall && cnt_q == CNT_FULL) state_d = S_RACK;
            S_RACK:
                if (scl_rise) state_d = sda_s ? S_WAIT : S_RNEXT;
            S_RNEXT:
                if (scl_fall) state_d = S_RDATA;
            default: state_d = S_IDLE;
        endcase
        if (start_ev)     state_d = S_DEV;
        else if (stop_ev) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shreg_q    <= '0;
            tx_q       <= '1;
            ack_on_q   <= 1'b0;
            rw_q       <= 1'b0;
            staged_q   <= 1'b0;
            stg_we_o   <= 1'b0;
            stg_addr_o <= '0;
            stg_data_o <= '0;
            commit_o   <= 1'b0;
            cancel_o   <= 1'b0;
        end else begin
            stg_we_o <= 1'b0;
            commit_o <= 1'b0;
            cancel_o <= 1'b0;
            if (start_ev) begin
                cnt_q    <= '0;
                ack_on_q <= 1'b0;
                staged_q <= 1'b0;
                cancel_o <= staged_q;
            end else if (stop_ev) begin
                cnt_q    <= '0;
                ack_on_q <= 1'b0;
                staged_q <= 1'b0;
                commit_o <= staged_q;
            end else begin
                unique case (state_q)
                    S_DEV, S_WADDR, S_WDATA: begin
                        if (scl_rise) begin
                            shreg_q <= rx_byte;
                            cnt_q   <= last_bit ? '0 : cnt_q + CW'(1);
                            if (last_bit && state_q == S_DEV) rw_q <= sda_s;
                            if (last_bit && state_q == S_WDATA) begin
                                stg_we_o   <= 1'b1;
                                stg_addr_o <= ptr_i;
                                stg_data_o <= rx_byte;
                                staged_q   <= 1'b1;
                            end
                        end
                    end
                    S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK: begin
                        if (scl_fall) begin
                            ack_on_q <= ~ack_on_q;
                            if (ack_on_q && state_q == S_DEV_ACK && rw_q) begin
                                tx_q  <= mem_data_i;
                                cnt_q <= '0;
                            end
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise) cnt_q <= cnt_q + CW'(1);
                        else if (scl_fall && cnt_q != CNT_FULL)
                            tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
                    end
                    S_RNEXT: begin
                        if (scl_fall) begin
                            tx_q  <= mem_data_i;
                            cnt_q <= '0;
                        end
                    end
                    S_IDLE, S_WAIT, S_RACK: begin
                        cnt_q <= cnt_q;
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_low_o      = 1'b0;
        ctr_load_o     = 1'b0;
        ctr_inc_page_o = 1'b0;
        ctr_inc_lin_o  = 1'b0;
        ctr_val_o      = rx_byte;
        unique case (state_q)
            S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK: sda_low_o = ack_on_q;
            S_RDATA: sda_low_o = ~tx_q[BYTE_W-1];
            default: sda_low_o = 1'b0;
        endcase
        if (state_q == S_WADDR && scl_rise && last_bit) ctr_load_o = 1'b1;
        if (state_q == S_WDATA && scl_rise && last_bit) ctr_inc_page_o = 1'b1;
        if (scl_fall && ((state_q == S_DEV_ACK && ack_on_q && rw_q) || state_q == S_RNEXT))
            ctr_inc_lin_o = 1'b1;
    end

    AST_SDA_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> !scl_s); // R12

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEV && scl_rise && last_bit && busy_i) |=> state_q != S_DEV_ACK); // R4

    AST_STAGE_IN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we_o |-> $past(state_q) == S_WDATA); // R5

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_ev)); // R6

    AST_CANCEL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> $past(start_ev)); // R6

    AST_RELEASE_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RACK && scl_rise && sda_s) |=> !sda_low_o); // R10
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
    import twi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    parameter int         AW          = 8,
    parameter int         PAGE_W      = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_low_o,
    input  logic [2:0]        chip_sel_i,
    input  logic              wcyc_busy_i,
    output logic              stg_we_o,
    output logic [AW-1:0]     stg_addr_o,
    output logic [BYTE_W-1:0] stg_data_o,
    output logic              commit_o,
    output logic              cancel_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [BYTE_W-1:0] mem_data_i
);
    logic [1:0]    lines_s;
    logic [AW-1:0] ptr;
    logic          ctr_load, ctr_inc_lin, ctr_inc_page;
    logic [AW-1:0] ctr_val;

    twi_line_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_s)
    );

    twi_addr_ctr #(.AW(AW), .PW(PAGE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (ctr_val),
        .inc_lin_i  (ctr_inc_lin),
        .inc_page_i (ctr_inc_page),
        .ptr_o      (ptr)
    );

    twi_fsm #(.DEV_TYPE(DEV_TYPE), .AW(AW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_s          (lines_s[1]),
        .sda_s          (lines_s[0]),
        .chip_sel_i     (chip_sel_i),
        .busy_i         (wcyc_busy_i),
        .mem_data_i     (mem_data_i),
        .ptr_i          (ptr),
        .sda_low_o      (sda_low_o),
        .stg_we_o       (stg_we_o),
        .stg_addr_o     (stg_addr_o),
        .stg_data_o     (stg_data_o),
        .commit_o       (commit_o),
        .cancel_o       (cancel_o),
        .ctr_load_o     (ctr_load),
        .ctr_val_o      (ctr_val),
        .ctr_inc_lin_o  (ctr_inc_lin),
        .ctr_inc_page_o (ctr_inc_page)
    );

    assign mem_addr_o = ptr;
endmodule

// File: tb/eeprom_twi_slave_test.sv
module eeprom_twi_slave_test;
    localparam int Q        = 5;
    localparam int BUSY_CYC = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic sda_low_o, stg_we_o, commit_o, cancel_o, busy;
    logic [7:0] stg_addr_o, stg_data_o, mem_addr_o, mem_data;

    logic [7:0] mem [256];
    logic [7:0] refm [256];
    logic [7:0] pend_a [$];
    logic [7:0] pend_d [$];
    logic [7:0] exp_q [$];
    logic [7:0] rx_q [$];
    string      tag_q [$];
    int busy_cnt = 0;
    int commits = 0, cancels = 0;
    int checks = 0, errors = 0;
    logic [7:0] eptr = 8'h00;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_bus  = ~(m_low | sda_low_o);
    assign busy     = (busy_cnt != 0);
    assign mem_data = mem[mem_addr_o];

    eeprom_twi_slave uut (
        .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_bus),
        .sda_low_o (sda_low_o), .chip_sel_i (STRAP), .wcyc_busy_i (busy),
        .stg_we_o (stg_we_o), .stg_addr_o (stg_addr_o), .stg_data_o (stg_data_o),
        .commit_o (commit_o), .cancel_o (cancel_o),
        .mem_addr_o (mem_addr_o), .mem_data_i (mem_data)
    );

    // write-cycle controller model
    always @(posedge clk) begin
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (stg_we_o) begin
            pend_a.push_back(stg_addr_o);
            pend_d.push_back(stg_data_o);
        end
        if (cancel_o) begin
            cancels <= cancels + 1;
            pend_a.delete();
            pend_d.delete();
        end
        if (commit_o) begin
            commits <= commits + 1;
            busy_cnt <= BUSY_CYC;
            foreach (pend_a[i]) mem[pend_a[i]] <= pend_d[i];
            pend_a.delete();
            pend_d.delete();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rx_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = rx_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(g == e, t, g, e);
        end
    end

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic m_start;
        m_low = 1'b0; wq(); m_scl = 1'b1; wq(); m_low = 1'b1; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic m_stop;
        m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq(2);
    endtask

    task automatic m_clock(output logic b);
        m_low = 1'b0; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic m_send(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_low = ~v[i]; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        end
        m_clock(b);
        acked = ~b;
    endtask

    task automatic m_recv(input bit ack_it, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_clock(b);
            v[i] = b;
        end
        m_low = ack_it; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        m_low = 1'b0;
    endtask

    task automatic read_run(input int n, input string tag);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(refm[eptr]);
            tag_q.push_back(tag);
            eptr = eptr + 8'd1;
            m_recv(i < n - 1, v);
            rx_q.push_back(v);
        end
        wq(2);
    endtask

    task automatic page_write(input logic [7:0] a, input logic [7:0] d [], input string tag);
        logic ak;
        m_start;
        m_send(DEV_W, ak); chk(ak, {tag, " select ack"}, ak, 1);
        m_send(a, ak);     chk(ak, {tag, " word addr ack"}, ak, 1);
        eptr = a;
        foreach (d[i]) begin
            m_send(d[i], ak); chk(ak, {tag, " data ack"}, ak, 1);
            refm[eptr] = d[i];
            eptr = {eptr[7:3], eptr[2:0] + 3'd1};
        end
        m_stop;
    endtask

    task automatic random_read(input logic [7:0] a, input int n, input string tag);
        logic ak;
        m_start;
        m_send(DEV_W, ak); chk(ak, {tag, " dummy select ack"}, ak, 1);
        m_send(a, ak);     chk(ak, {tag, " dummy addr ack"}, ak, 1);
        eptr = a;
        m_start;
        m_send(DEV_R, ak); chk(ak, {tag, " read select ack"}, ak, 1);
        read_run(n, tag);
        m_stop;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ak, b;
        logic [7:0] v;
        int c0;
        logic [7:0] pg [];
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i) ^ 8'h5A;
            refm[i] = 8'(i) ^ 8'h5A;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_low_o == 1'b0 && stg_we_o == 1'b0 && commit_o == 1'b0, "reset R12", sda_low_o, 0);

        // R3: wrong strap
        m_start;
        m_send({4'b1010, 3'b001, 1'b0}, ak);
        chk(!ak, "R3 mismatch not acked", ak, 0);
        m_send(8'h00, ak);
        chk(!ak, "R3 ignored until start", ak, 0);
        m_stop;

        // R2 R5: byte write, R6 commit
        pg = new[1]; pg[0] = 8'hA5;
        c0 = commits;
        page_write(8'h10, pg, "R2 R5 byte write");
        wq();
        chk(commits == c0 + 1, "R6 commit on stop", commits, c0 + 1);

        // R4: poll while busy
        m_start;
        m_send(DEV_W, ak);
        chk(!ak, "R4 busy select nack", ak, 0);
        m_stop;
        repeat (BUSY_CYC) @(negedge clk);
        c0 = commits;
        m_start;
        m_send(DEV_W, ak);
        chk(ak, "R4 select ack after busy", ak, 1);
        m_stop;
        wq();
        chk(commits == c0, "R6 no commit without data", commits, c0);

        // R5 page write with wrap
        pg = new[5];
        pg[0] = 8'h11; pg[1] = 8'h22; pg[2] = 8'h33; pg[3] = 8'h44; pg[4] = 8'h55;
        page_write(8'h3D, pg, "R5 page wrap");
        repeat (BUSY_CYC + 10) @(negedge clk);

        // R8 R9 random then sequential
        random_read(8'h3E, 4, "R8 R9 random sequential");

        // R7 current address
        m_start;
        m_send(DEV_R, ak); chk(ak, "R7 current select ack", ak, 1);
        read_run(1, "R7 current address");
        m_stop;

        // R9 wrap 255 -> 0
        random_read(8'hFE, 3, "R9 array wrap");

        // R10 released after nack
        m_start;
        m_send(DEV_R, ak); chk(ak, "R10 select ack", ak, 1);
        read_run(1, "R10 data");
        begin
            logic all_hi;
            all_hi = 1'b1;
            for (int i = 0; i < 9; i++) begin
                m_clock(b);
                all_hi &= b;
            end
            chk(all_hi, "R10 line released after nack", all_hi, 1);
        end
        m_stop;

        // R1 R6: start aborts write with staged data
        c0 = commits;
        begin
            int k0;
            k0 = cancels;
            m_start;
            m_send(DEV_W, ak);
            m_send(8'h80, ak);
            m_send(8'hC3, ak);
            chk(ak, "R5 staged byte ack", ak, 1);
            m_start;
            wq();
            chk(cancels == k0 + 1, "R6 cancel on start", cancels, k0 + 1);
            m_send(DEV_W, ak);
            chk(ak, "R1 restart select ack", ak, 1);
            m_send(8'h80, ak);
            eptr = 8'h80;
            m_start;
            m_send(DEV_R, ak);
            read_run(1, "R1 R6 aborted write kept old data");
            m_stop;
            wq();
            chk(commits == c0, "R6 no commit after abort", commits, c0);
        end

        // R11 recovery from mid-read
        m_start;
        m_send(DEV_R, ak);
        eptr = eptr + 8'd1;
        for (int i = 0; i < 4; i++) m_clock(b);
        m_start;
        for (int i = 0; i < 9; i++) m_clock(b);
        m_start;
        m_stop;
        wq();
        chk(sda_low_o == 1'b0, "R11 idle after recovery", sda_low_o, 0);
        m_start;
        m_send(DEV_R, ak); chk(ak, "R11 select ack after recovery", ak, 1);
        read_run(1, "R11 read after recovery");
        m_stop;

        wq(4);
        chk(exp_q.size() == 0, "scoreboard drained R9", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule